// File: doc/BRIEF.md
# TDM Frame Sync Generator

This block keeps the frame and slot timing for a time-division-multiplexed serial bus that several processors share. A bit-rate strobe (`bit_tick`) drives a word timer that marks the start of each serial word with a one-clock `word_strobe`. A slot counter advances on each word and wraps after 8 or 16 slots, as set by `cfg_frame16`. The position of the current word in the frame appears on `slot_num`.

With multiprocessor operation enabled (`cfg_mp_en`), the unit runs in one of two roles. As the sync master (`cfg_master` = 1) it drives the frame sync line, holding it low during slot 0 and high for the rest of the frame, so the sync rate is the word rate divided by the frame length. A master always transmits in slot 0. As a slave it waits for a falling edge on `sync_in`. That edge marks slot 0 and restarts the word timer and the slot counter at once, wherever they were. In both roles the block compares the slot counter with the transmit slot and drives an active-low slot-valid enable. It also sets the direction of the serial address line.

The control state machine has three states. FS_OFF: multiprocessor operation is disabled and the counters are held at zero. FS_HUNT: the slave waits for its first sync edge. FS_RUN: words and slots are being counted. Its transitions are named as follows. OFF_TO_RUN is taken on enable when master. OFF_TO_HUNT is taken on enable when slave. HUNT_TO_RUN is taken on a sync falling edge, or at once if master is selected. RUN_RESYNC is a self-loop on a slave sync edge that restarts the counters. Any state goes to FS_OFF when `cfg_mp_en` is low (EXIT).

Top module: `tdm_frame_sync`

## Requirements
- R1: While `rst_n` is low and after reset with `cfg_mp_en` low: `word_strobe`=0, `slot_num`=0, `sync_out`=1, `sync_oe`=0, `slot_valid_n`=1, `addr_oe`=1.
- R2: In FS_RUN the word timer counts `bit_tick` pulses. The clock cycle after the 16th tick of a word, `word_strobe` is high for one cycle and `slot_num` has advanced by one.
- R3: The frame holds 16 slots (0..15) when `cfg_frame16`=1 and 8 slots (0..7) when it is 0. The slot after the last one is 0.
- R4: When `cfg_mp_en` rises with `cfg_master`=1, the next cycle shows `word_strobe`=1 and `slot_num`=0, which is the start of slot 0.
- R5: Master with multiprocessor on: `sync_oe`=1. `sync_out` is 0 throughout slot 0 and 1 in every other slot, so it falls once per frame. In any other configuration `sync_oe`=0 and `sync_out`=1.
- R6: A slave in FS_HUNT issues no `word_strobe` and keeps `slot_valid_n`=1. A falling edge on `sync_in` (sampled 1 on one clock and 0 on the next) gives `word_strobe`=1 with `slot_num`=0 one cycle later.
- R7: A slave in FS_RUN that sees a `sync_in` falling edge restarts at slot 0, bit 0. On the next cycle `word_strobe`=1 and `slot_num`=0. This restart wins over a word wrap in the same cycle.
- R8: In master mode `sync_in` has no effect on the counters or the strobe.
- R9: `slot_valid_n` is 0 exactly while in FS_RUN with `slot_num` equal to the transmit slot, which is 0 for a master and `cfg_tx_slot` for a slave. A transmit slot beyond the frame length never matches.
- R10: `addr_oe`=1 when `cfg_mp_en`=0. With `cfg_mp_en`=1 it is 1 only while `slot_valid_n`=0.
- R11: When `cfg_mp_en` falls, the next cycle has `slot_num`=0 and `word_strobe`=0, and the block is back in FS_OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| cfg_mp_en | input | 1 | Multiprocessor (TDM) operation enable |
| cfg_master | input | 1 | 1 = drive frame sync, 0 = follow `sync_in` |
| cfg_frame16 | input | 1 | 1 = 16-slot frame, 0 = 8-slot frame |
| cfg_tx_slot | input | 4 | Transmit slot used as a slave |
| sync_in | input | 1 | Frame sync line as received |
| sync_out | output | 1 | Frame sync value driven as master |
| sync_oe | output | 1 | Drive enable for the sync line |
| word_strobe | output | 1 | One-cycle pulse at the start of each word |
| slot_num | output | 4 | Current slot number |
| slot_valid_n | output | 1 | Active-low enable for own transmit slot |
| addr_oe | output | 1 | Drive enable for the serial address line |

## Verification
A wrong bit count or slot count shows at the ports within one word period: `word_strobe` arrives a tick early or late, or `slot_num` takes a value out of sequence. For the master, `sync_out` then falls in the wrong place. A wrong state shows within a cycle of the event that should have moved it. Examples are a slave that strobes before any sync edge, a master that reacts to `sync_in`, or counters that stay non-zero after disable. A wrong transmit-slot compare shows as `slot_valid_n` and `addr_oe` being low for the wrong word, or never low within the frame. Comparing against a reference model on every clock catches each of these on the first cycle it diverges.

// File: rtl/tdm_fs_pkg.sv
package tdm_fs_pkg;

    typedef enum logic [1:0] {
        FS_OFF  = 2'd0,
        FS_HUNT = 2'd1,
        FS_RUN  = 2'd2
    } fs_state_e;

endpackage

// File: rtl/tdm_fs_edge.sv
// Falling-edge detector for the received frame sync line.
module tdm_fs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic fall
);

    logic prev_q;

    // Reset to 0 so a line held low from reset does not count as an edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= line_in;
        end
    end

    assign fall = prev_q & ~line_in;

endmodule

// File: rtl/tdm_fs_word_timer.sv
// Counts bit ticks within one serial word and flags the last tick.
module tdm_fs_word_timer #(
    parameter int WORD_BITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic count_en,
    input  logic tick,
    output logic word_end
);

    localparam int BW = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(WORD_BITS - 1);

    logic [BW-1:0] bit_q;

    assign word_end = count_en & tick & ~restart & (bit_q == LAST_BIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= '0;
        end else if (restart) begin
            bit_q <= '0;
        end else if (word_end) begin
            bit_q <= '0;
        end else if (count_en && tick) begin
            bit_q <= bit_q + 1'b1;
        end
    end

endmodule

// File: rtl/tdm_fs_slot_ctr.sv
// Slot counter: advances once per word and wraps at the programmed last slot.
module tdm_fs_slot_ctr #(
    parameter int MAX_SLOTS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         restart,
    input  logic                         advance,
    input  logic [$clog2(MAX_SLOTS)-1:0] last_slot,
    output logic [$clog2(MAX_SLOTS)-1:0] slot
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot <= '0;
        end else if (restart) begin
            slot <= '0;
        end else if (advance) begin
            if (slot == last_slot) begin
                slot <= '0;
            end else begin
                slot <= slot + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tdm_frame_sync.sv
// TDM frame sync generator: master/slave frame timing and slot enables.
module tdm_frame_sync
    import tdm_fs_pkg::*;
#(
    parameter int WORD_BITS   = 16,
    parameter int MAX_SLOTS   = 16,
    parameter int SHORT_SLOTS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bit_tick,
    input  logic                         cfg_mp_en,
    input  logic                         cfg_master,
    input  logic                         cfg_frame16,
    input  logic [$clog2(MAX_SLOTS)-1:0] cfg_tx_slot,
    input  logic                         sync_in,
    output logic                         sync_out,
    output logic                         sync_oe,
    output logic                         word_strobe,
    output logic [$clog2(MAX_SLOTS)-1:0] slot_num,
    output logic                         slot_valid_n,
    output logic                         addr_oe
);

    localparam int SW = $clog2(MAX_SLOTS);
    localparam logic [SW-1:0] LONG_LAST  = SW'(MAX_SLOTS - 1);
    localparam logic [SW-1:0] SHORT_LAST = SW'(SHORT_SLOTS - 1);

    fs_state_e state_q, state_d;
    logic      strobe_q, strobe_d;
    logic      sync_fall;
    logic      restart;
    logic      count_en;
    logic      word_end;
    logic      running;
    logic [SW-1:0] last_slot;
    logic [SW-1:0] own_slot;

    tdm_fs_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (sync_in),
        .fall    (sync_fall)
    );

    tdm_fs_word_timer #(.WORD_BITS(WORD_BITS)) u_word (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .count_en (count_en),
        .tick     (bit_tick),
        .word_end (word_end)
    );

    tdm_fs_slot_ctr #(.MAX_SLOTS(MAX_SLOTS)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .advance   (word_end),
        .last_slot (last_slot),
        .slot      (slot_num)
    );

    assign last_slot = cfg_frame16 ? LONG_LAST : SHORT_LAST;
    assign count_en  = (state_q == FS_RUN) && cfg_mp_en;
    // Counters clear outside counting and on a slave resync.
    assign restart   = !count_en || (!cfg_master && sync_fall);

    // Next state and strobe.
    always_comb begin
        state_d  = state_q;
        strobe_d = 1'b0;
        unique case (state_q)
            FS_OFF: begin
                if (cfg_mp_en) begin
                    if (cfg_master) begin           // OFF_TO_RUN
                        state_d  = FS_RUN;
                        strobe_d = 1'b1;
                    end else begin                  // OFF_TO_HUNT
                        state_d  = FS_HUNT;
                    end
                end
            end
            FS_HUNT: begin
                if (!cfg_mp_en) begin               // EXIT
                    state_d = FS_OFF;
                end else if (cfg_master || sync_fall) begin  // HUNT_TO_RUN
                    state_d  = FS_RUN;
                    strobe_d = 1'b1;
                end
            end
            FS_RUN: begin
                if (!cfg_mp_en) begin               // EXIT
                    state_d = FS_OFF;
                end else if (!cfg_master && sync_fall) begin // RUN_RESYNC
                    strobe_d = 1'b1;
                end else begin
                    strobe_d = word_end;
                end
            end
            default: begin
                state_d = FS_OFF;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= FS_OFF;
            strobe_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            strobe_q <= strobe_d;
        end
    end

    // Outputs.
    always_comb begin
        running      = (state_q == FS_RUN);
        own_slot     = cfg_master ? '0 : cfg_tx_slot;
        word_strobe  = strobe_q;
        sync_oe      = cfg_mp_en && cfg_master;
        sync_out     = !(sync_oe && running && (slot_num == '0));
        slot_valid_n = !(running && (slot_num == own_slot));
        addr_oe      = !cfg_mp_en || !slot_valid_n;
    end

endmodule

// File: rtl/tdm_frame_sync_chk.sv
module tdm_frame_sync_chk #(
    parameter int SLOT_W      = 4,
    parameter int SHORT_SLOTS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_mp_en,
    input logic              cfg_master,
    input logic              cfg_frame16,
    input logic              word_strobe,
    input logic [SLOT_W-1:0] slot_num,
    input logic              sync_out,
    input logic              sync_oe,
    input logic              slot_valid_n,
    input logic              addr_oe
);

    a_r2_slot_moves_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !word_strobe |-> ($stable(slot_num) || slot_num == '0));

    a_r2_master_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && word_strobe) |=> !word_strobe);

    a_r3_short_frame_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_frame16 |-> (int'(slot_num) < SHORT_SLOTS));

    a_r5_sync_falls_at_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mp_en && cfg_master && $fell(sync_out)) |-> (word_strobe && slot_num == '0));

    a_r9_master_uses_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mp_en && cfg_master && !slot_valid_n) |-> (slot_num == '0));

    a_r10_idle_directions: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mp_en |-> (addr_oe && !sync_oe));

    a_r11_exit_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_mp_en) |=> (slot_num == '0 && !word_strobe));

endmodule

bind tdm_frame_sync tdm_frame_sync_chk #(
    .SLOT_W      (SW),
    .SHORT_SLOTS (SHORT_SLOTS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_mp_en    (cfg_mp_en),
    .cfg_master   (cfg_master),
    .cfg_frame16  (cfg_frame16),
    .word_strobe  (word_strobe),
    .slot_num     (slot_num),
    .sync_out     (sync_out),
    .sync_oe      (sync_oe),
    .slot_valid_n (slot_valid_n),
    .addr_oe      (addr_oe)
);

// File: tb/tb_tdm_frame_sync.sv
`timescale 1ns/1ps
module tb_tdm_frame_sync;

    localparam int WB = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       cfg_mp_en = 1'b0;
    logic       cfg_master = 1'b0;
    logic       cfg_frame16 = 1'b1;
    logic [3:0] cfg_tx_slot = 4'd0;
    logic       sync_in = 1'b1;
    logic       sync_out, sync_oe, word_strobe, slot_valid_n, addr_oe;
    logic [3:0] slot_num;

    tdm_frame_sync dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .cfg_mp_en(cfg_mp_en),
        .cfg_master(cfg_master), .cfg_frame16(cfg_frame16), .cfg_tx_slot(cfg_tx_slot),
        .sync_in(sync_in), .sync_out(sync_out), .sync_oe(sync_oe),
        .word_strobe(word_strobe), .slot_num(slot_num),
        .slot_valid_n(slot_valid_n), .addr_oe(addr_oe)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int tick_div = 1;
    int sync_low_left = 0;
    int strobes_seen = 0;
    int valid_low_seen = 0;
    int max_slot_seen = 0;
    bit finished = 1'b0;

    // Behavioural reference: 0 = off, 1 = hunting, 2 = running.
    int m_state = 0, m_bit = 0, m_slot = 0, m_strobe = 0, m_prev = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_bit = 0; m_slot = 0; m_strobe = 0; m_prev = 0;
        end else begin
            int fall;
            int last;
            fall = (m_prev == 1 && sync_in == 1'b0) ? 1 : 0;
            m_prev = sync_in ? 1 : 0;
            last = cfg_frame16 ? 15 : 7;
            if (m_state == 0) begin
                m_strobe = 0; m_bit = 0; m_slot = 0;
                if (cfg_mp_en) begin
                    if (cfg_master) begin m_state = 2; m_strobe = 1; end
                    else m_state = 1;
                end
            end else if (m_state == 1) begin
                m_strobe = 0;
                if (!cfg_mp_en) m_state = 0;
                else if (cfg_master || fall == 1) begin m_state = 2; m_strobe = 1; end
            end else begin
                if (!cfg_mp_en) begin
                    m_state = 0; m_bit = 0; m_slot = 0; m_strobe = 0;
                end else if (!cfg_master && fall == 1) begin
                    m_bit = 0; m_slot = 0; m_strobe = 1;
                end else if (bit_tick) begin
                    if (m_bit == WB - 1) begin
                        m_bit = 0;
                        m_slot = (m_slot == last) ? 0 : m_slot + 1;
                        m_strobe = 1;
                    end else begin
                        m_bit = m_bit + 1;
                        m_strobe = 0;
                    end
                end else begin
                    m_strobe = 0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic compare_model();
        int own, e_valid_n, e_sync_oe, e_sync, e_addr, run;
        run = (m_state == 2) ? 1 : 0;
        own = cfg_master ? 0 : int'(cfg_tx_slot);
        e_valid_n = (run == 1 && m_slot == own) ? 0 : 1;
        e_sync_oe = (cfg_mp_en && cfg_master) ? 1 : 0;
        e_sync = (e_sync_oe == 1 && run == 1 && m_slot == 0) ? 0 : 1;
        e_addr = (!cfg_mp_en || e_valid_n == 0) ? 1 : 0;
        chk(int'(word_strobe) == m_strobe, "R2 word_strobe", int'(word_strobe), m_strobe);
        chk(int'(slot_num) == m_slot, "R3 slot_num", int'(slot_num), m_slot);
        chk(int'(sync_oe) == e_sync_oe, "R5 sync_oe", int'(sync_oe), e_sync_oe);
        chk(int'(sync_out) == e_sync, "R5 sync_out", int'(sync_out), e_sync);
        chk(int'(slot_valid_n) == e_valid_n, "R9 slot_valid_n", int'(slot_valid_n), e_valid_n);
        chk(int'(addr_oe) == e_addr, "R10 addr_oe", int'(addr_oe), e_addr);
    endtask

    task automatic tally_clear();
        strobes_seen = 0; valid_low_seen = 0; max_slot_seen = 0;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_n) compare_model();
            if (word_strobe) strobes_seen++;
            if (!slot_valid_n) valid_low_seen++;
            if (int'(slot_num) > max_slot_seen) max_slot_seen = int'(slot_num);
            cyc++;
            bit_tick = (tick_div != 0) && (cyc % tick_div == 0);
            if (sync_low_left > 0) begin
                sync_in = 1'b0;
                sync_low_left--;
            end else begin
                sync_in = 1'b1;
            end
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int s0;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(word_strobe == 1'b0 && slot_num == 4'd0, "R1 strobe/slot in reset", int'(slot_num), 0);
        chk(sync_out == 1'b1 && sync_oe == 1'b0, "R1 sync in reset", int'(sync_out), 1);
        chk(slot_valid_n == 1'b1 && addr_oe == 1'b1, "R1 enables in reset", int'(slot_valid_n), 1);
        rst_n = 1'b1;
        step(4);
        chk(slot_num == 4'd0 && word_strobe == 1'b0, "R1 idle after reset", int'(slot_num), 0);

        // R10: multiprocessor off, sync edges ignored, address line driven
        sync_low_left = 3;
        tally_clear();
        step(40);
        chk(strobes_seen == 0, "R10 no strobes while off", strobes_seen, 0);
        chk(addr_oe == 1'b1, "R10 addr_oe while off", int'(addr_oe), 1);

        // R4/R5: master, 16 slots, tick every other cycle
        cfg_master = 1'b1; cfg_frame16 = 1'b1; tick_div = 2;
        cfg_mp_en = 1'b1;
        step(1);
        chk(word_strobe == 1'b1 && slot_num == 4'd0, "R4 master start slot 0", int'(word_strobe), 1);
        chk(sync_out == 1'b0, "R5 sync low in slot 0", int'(sync_out), 0);
        tally_clear();
        step(2 * WB * 16 * 2);
        chk(strobes_seen == 32, "R2 one strobe per word (16 slots)", strobes_seen, 32);
        chk(max_slot_seen == 15, "R3 16-slot frame reaches 15", max_slot_seen, 15);
        chk(valid_low_seen == 2 * WB * 2, "R9 master valid only slot 0", valid_low_seen, 2 * WB * 2);

        // R8: master ignores sync_in
        tick_div = 0;
        step(2);
        s0 = int'(slot_num);
        tally_clear();
        sync_low_left = 2;
        step(8);
        chk(int'(slot_num) == s0 && strobes_seen == 0, "R8 master ignores sync_in", int'(slot_num), s0);
        tick_div = 1;
        step(37);

        // R11: disable
        cfg_mp_en = 1'b0;
        step(1);
        chk(slot_num == 4'd0 && word_strobe == 1'b0, "R11 exit clears", int'(slot_num), 0);
        chk(sync_out == 1'b1 && sync_oe == 1'b0, "R11 sync released", int'(sync_oe), 0);

        // R3: master, 8 slots
        cfg_frame16 = 1'b0;
        step(2);
        cfg_mp_en = 1'b1;
        tally_clear();
        step(WB * 8 * 3 + 5);
        chk(max_slot_seen == 7, "R3 8-slot frame wraps after 7", max_slot_seen, 7);
        cfg_mp_en = 1'b0;
        step(3);

        // R6: slave hunting
        cfg_master = 1'b0; cfg_frame16 = 1'b1; cfg_tx_slot = 4'd5;
        step(2);
        cfg_mp_en = 1'b1;
        tally_clear();
        step(60);
        chk(strobes_seen == 0, "R6 no strobe while hunting", strobes_seen, 0);
        chk(valid_low_seen == 0, "R6 no valid while hunting", valid_low_seen, 0);
        sync_low_left = 2;
        step(2);
        chk(word_strobe == 1'b1 && slot_num == 4'd0, "R6 sync edge starts slot 0", int'(slot_num), 0);
        tally_clear();
        step(WB * 16 - 1);
        chk(valid_low_seen == WB, "R9 slave valid for one word in slot 5", valid_low_seen, WB);

        // R7: resync mid-word with slow ticks
        tick_div = 3;
        step(WB * 3 * 2 + 7);
        sync_low_left = 1;
        step(2);
        chk(word_strobe == 1'b1 && slot_num == 4'd0, "R7 resync to slot 0", int'(slot_num), 0);
        step(WB * 3 * 5);
        tick_div = 1;
        step(WB * 4 + 3);
        sync_low_left = 4;
        step(2);
        chk(word_strobe == 1'b1 && slot_num == 4'd0, "R7 second resync", int'(slot_num), 0);
        step(WB * 20);

        // R9: transmit slot beyond 8-slot frame never matches
        cfg_mp_en = 1'b0;
        step(2);
        cfg_frame16 = 1'b0; cfg_tx_slot = 4'd12;
        cfg_mp_en = 1'b1;
        step(3);
        sync_low_left = 2;
        tally_clear();
        step(WB * 8 * 2 + 4);
        chk(valid_low_seen == 0, "R9 out-of-frame slot never valid", valid_low_seen, 0);
        chk(max_slot_seen == 7, "R3 slave 8-slot wrap", max_slot_seen, 7);
        cfg_mp_en = 1'b0;
        step(2);
        chk(addr_oe == 1'b1 && slot_num == 4'd0, "R11 slave exit", int'(addr_oe), 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule